// File: doc/BRIEF.md
# Streaming Times-Three Datapath

This block multiplies an unsigned operand by three without a multiplier. The first adder forms the doubled value A+A. The second adder adds that doubled value to the operand once more. The operand is carried down the pipe beside the doubled value, so each second-stage add pairs 2A with the operand that produced it. The block takes one operand per clock and returns one result per clock after a fixed latency. There is no stall and no backpressure.

The parameter `DEEP` selects one of two forms. The shallow form (`DEEP=0`) has one register after each adder. The deep form (`DEEP=1`) cuts each adder at the half-word boundary of the result width. The lower half of the sum and its carry-out are registered, and the carry is fed into the upper-half add in the next stage. This halves the adder depth per stage at the cost of two more clocks of latency.

A valid flag travels with every operand. The result is `DATA_W+2` bits wide, so three times the largest operand always fits. The data registers have no reset. Data is meaningless while its valid flag is low.

Top module: `tri3_pipe`

## Requirements
- R1: Whenever `out_valid` is 1, `out_data` equals 3 × the operand that was accepted with it, zero-extended to `DATA_W+2` bits. This includes the all-ones operand and the values 1→3, 4→12, 7→21, 17→51 and 23→69.
- R2: With `DEEP=0`, an operand captured at a rising edge has its result and valid flag driven after the 2nd rising edge, counting the capturing edge.
- R3: With `DEEP=1`, the same result and valid flag are driven after the 4th rising edge, counting the capturing edge.
- R4: Operands presented on consecutive clocks are all accepted. Their results leave on consecutive clocks in the order the operands arrived.
- R5: A clock with `in_valid`=0 produces a clock with `out_valid`=0 exactly one latency later. The results around the gap are unaffected.
- R6: The synchronous, active-high reset `rst` clears the valid flag of every stage and wins over an operand presented at the same edge. `out_valid` is 0 after any edge at which `rst` is 1.
- R7: In the deep form, the carry out of the lower half (bits below `(DATA_W+2)/2`) is registered and added into the upper half one stage later. Operands whose doubled or tripled value carries across that boundary give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand on `in_data` is to be accepted this clock |
| in_data | input | DATA_W | Unsigned operand |
| out_valid | output | 1 | `out_data` holds a result this clock |
| out_data | output | DATA_W+2 | Three times the matching operand |

## Verification
Two events can meet at the same clock edge: a reset and an operand arriving with its valid flag high. Results may also still be in flight in later stages at that moment. The bench raises `rst` on an edge where `in_valid` is 1 and several operands are still in transit in both forms. It then expects `out_valid` to stay low until the first operand presented after the reset has had its full latency. A dropped reset or a leaked operand shows up as a valid-flag miscompare against the bench's own per-cycle record of what was presented.

// File: rtl/tri3_pkg.sv
package tri3_pkg;

    // Registers each adder contributes: one when whole, two when cut in half.
    function automatic int regs_per_add(input bit deep);
        return deep ? 2 : 1;
    endfunction

    // Clocks from capturing edge to the edge that drives the result.
    function automatic int pipe_latency(input bit deep);
        return 2 * regs_per_add(deep);
    endfunction

    // Width of the lower slice when an add is cut.
    function automatic int low_slice(input int width);
        return width / 2;
    endfunction

endpackage

// File: rtl/tri3_add_stage.sv
module tri3_add_stage #(
    parameter int W     = 18,
    parameter int KW    = 16,
    parameter bit SPLIT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          v_i,
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  y_i,
    input  logic [KW-1:0] k_i,
    output logic          v_o,
    output logic [W-1:0]  s_o,
    output logic [KW-1:0] k_o
);

    generate
        if (SPLIT) begin : g_split
            localparam int LW = tri3_pkg::low_slice(W);
            localparam int HW = W - LW;

            logic [LW:0]   lo_full;
            logic          va_q;
            logic [LW-1:0] lo_q;
            logic          cy_q;
            logic [HW-1:0] xh_q;
            logic [HW-1:0] yh_q;
            logic [KW-1:0] ka_q;
            logic          vb_q;
            logic [W-1:0]  sum_q;
            logic [KW-1:0] kb_q;

            always_comb begin
                lo_full = {1'b0, x_i[LW-1:0]} + {1'b0, y_i[LW-1:0]};
            end

            // First half-stage: lower slice summed, carry and upper operands held.
            always_ff @(posedge clk) begin
                if (rst) begin
                    va_q <= 1'b0;
                end else begin
                    va_q <= v_i;
                end
            end

            always_ff @(posedge clk) begin
                lo_q <= lo_full[LW-1:0];
                cy_q <= lo_full[LW];
                xh_q <= x_i[W-1:LW];
                yh_q <= y_i[W-1:LW];
                ka_q <= k_i;
            end

            // Second half-stage: upper slice absorbs the registered carry.
            always_ff @(posedge clk) begin
                if (rst) begin
                    vb_q <= 1'b0;
                end else begin
                    vb_q <= va_q;
                end
            end

            always_ff @(posedge clk) begin
                sum_q <= {xh_q + yh_q + HW'(cy_q), lo_q};
                kb_q  <= ka_q;
            end

            assign v_o = vb_q;
            assign s_o = sum_q;
            assign k_o = kb_q;

            AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
                v_o |-> (s_o == $past(x_i + y_i, 2)))
                else $error("split add lost a carry"); // R7

        end else begin : g_flat
            logic          v_q;
            logic [W-1:0]  sum_q;
            logic [KW-1:0] k_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                end else begin
                    v_q <= v_i;
                end
            end

            always_ff @(posedge clk) begin
                sum_q <= x_i + y_i;
                k_q   <= k_i;
            end

            assign v_o = v_q;
            assign s_o = sum_q;
            assign k_o = k_q;
        end
    endgenerate

endmodule

// File: rtl/tri3_pipe.sv
module tri3_pipe #(
    parameter int DATA_W = 16,
    parameter bit DEEP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W+1:0] out_data
);

    localparam int OUT_W = DATA_W + 2;
    localparam int LAT   = tri3_pkg::pipe_latency(DEEP);

    logic [OUT_W-1:0]  opnd_ext;
    logic              dbl_v;
    logic [OUT_W-1:0]  dbl_sum;
    logic [DATA_W-1:0] dbl_opnd;
    logic [OUT_W-1:0]  dbl_opnd_ext;
    logic [DATA_W-1:0] tail_opnd;
    logic [2:0]        since_rst;

    assign opnd_ext     = OUT_W'(in_data);
    assign dbl_opnd_ext = OUT_W'(dbl_opnd);

    // Adder one: A + A, operand rides alongside.
    tri3_add_stage #(.W(OUT_W), .KW(DATA_W), .SPLIT(DEEP)) u_double (
        .clk (clk),
        .rst (rst),
        .v_i (in_valid),
        .x_i (opnd_ext),
        .y_i (opnd_ext),
        .k_i (in_data),
        .v_o (dbl_v),
        .s_o (dbl_sum),
        .k_o (dbl_opnd)
    );

    // Adder two: 2A + A using the operand that produced 2A.
    tri3_add_stage #(.W(OUT_W), .KW(DATA_W), .SPLIT(DEEP)) u_triple (
        .clk (clk),
        .rst (rst),
        .v_i (dbl_v),
        .x_i (dbl_sum),
        .y_i (dbl_opnd_ext),
        .k_i (dbl_opnd),
        .v_o (out_valid),
        .s_o (out_data),
        .k_o (tail_opnd)
    );

    // Clocks elapsed since reset, saturating at the latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 3'd0;
        end else if (since_rst != 3'(LAT)) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    AST_TRIPLE_OF_OPERAND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == OUT_W'(3 * {2'b00, tail_opnd})))
        else $error("result is not three times its operand"); // R1

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid)
        else $error("valid survived reset"); // R6

    AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT)) && !$past(in_valid, LAT) |-> !out_valid)
        else $error("bubble filled"); // R5

    generate
        if (DEEP) begin : g_lat_deep
            AST_LATENCY_DEEP: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)))
                else $error("deep latency wrong"); // R3
        end else begin : g_lat_flat
            AST_LATENCY_FLAT: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)))
                else $error("shallow latency wrong"); // R2
        end
    endgenerate

endmodule

// File: tb/tri3_pipe_tb_top.sv
`timescale 1ns/1ps
module tri3_pipe_tb_top;

    localparam int W     = 16;
    localparam int OW    = W + 2;
    localparam int DEPTH = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          sh_valid;
    logic [OW-1:0] sh_data;
    logic          dp_valid;
    logic [OW-1:0] dp_data;

    int vectors = 0;
    int fails   = 0;
    int idx     = 0;
    int base    = 0;
    bit done    = 1'b0;
    string phase = "reset";

    logic          hv [0:DEPTH-1];
    logic [W-1:0]  hd [0:DEPTH-1];

    always #2.5 clk = ~clk;

    tri3_pipe #(.DATA_W(W), .DEEP(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(sh_valid), .out_data(sh_data)
    );

    tri3_pipe #(.DATA_W(W), .DEEP(1'b1)) dut_deep_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(dp_valid), .out_data(dp_data)
    );

    function automatic logic [OW-1:0] times3(input logic [W-1:0] a);
        return OW'(a) * OW'(3);
    endfunction

    task automatic judge(input string form, input int j,
                         input logic v, input logic [OW-1:0] d);
        logic exp_v;
        exp_v = (j >= base) ? hv[j] : 1'b0;
        vectors++;
        if (v !== exp_v) begin
            fails++;
            $display("FAIL %s %s valid: got %0b expected %0b (cycle %0d)", phase, form, v, exp_v, idx);
        end
        if (exp_v === 1'b1) begin
            vectors++;
            if (d !== times3(hd[j])) begin
                fails++;
                $display("FAIL %s R1 %s data: got %0d expected %0d (operand %0d)",
                         phase, form, d, times3(hd[j]), hd[j]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] d);
        hv[idx]  = v;
        hd[idx]  = d;
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        @(negedge clk);
        judge("R2-shallow", idx - 1, sh_valid, sh_data);
        judge("R3-deep",    idx - 3, dp_valid, dp_data);
        idx++;
    endtask

    initial begin
        int seed_set;
        seed_set = $urandom(32'h00C0FFEE);
        // Reset held over several edges with no operands.
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (sh_valid !== 1'b0 || dp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset state: got %0b/%0b expected 0/0", sh_valid, dp_valid);
        end
        rst  = 1'b0;
        base = 0;

        phase = "R1 worked values";
        step(1'b1, 16'd7);
        step(1'b1, 16'd17);
        step(1'b1, 16'd4);
        step(1'b1, 16'd1);
        step(1'b1, 16'd23);
        step(1'b1, 16'hFFFF);
        step(1'b1, 16'd0);

        phase = "R7 half carry";
        step(1'b1, 16'h00FF);
        step(1'b1, 16'h0100);
        step(1'b1, 16'h00AB);
        step(1'b1, 16'h7FFF);
        step(1'b1, 16'h5555);

        phase = "R5 bubbles";
        step(1'b0, 16'hDEAD);
        step(1'b1, 16'd9);
        step(1'b0, 16'hBEEF);
        step(1'b0, 16'd0);
        step(1'b1, 16'hFFFF);
        step(1'b0, 16'd3);
        step(1'b1, 16'd2);

        phase = "R4 back-to-back";
        for (int n = 0; n < 40; n++) step(1'b1, 16'($urandom));

        // R6: reset at an edge where an operand is presented and others are in flight.
        phase = "R6 reset collision";
        step(1'b1, 16'd11);
        step(1'b1, 16'd12);
        hv[idx] = 1'b1; hd[idx] = 16'd13;
        in_valid = 1'b1; in_data = 16'd13; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        idx++;
        base = idx;
        vectors++;
        if (sh_valid !== 1'b0 || dp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R6 after reset: got %0b/%0b expected 0/0", sh_valid, dp_valid);
        end
        step(1'b1, 16'd21);
        step(1'b1, 16'd22);
        step(1'b0, 16'd0);
        step(1'b1, 16'd23);

        phase = "R4/R5 random";
        for (int n = 0; n < 500; n++) begin
            logic v;
            logic [W-1:0] d;
            v = (($urandom % 4) != 0);
            d = (($urandom % 16) == 0) ? 16'hFFFF : 16'($urandom);
            step(v, d);
        end

        phase = "flush";
        for (int n = 0; n < 6; n++) step(1'b0, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule